// File: doc/BRIEF.md
# Programmable Interlaced Raster Timing Generator

This block produces the raster timing for a serial digital video transmitter. It counts samples along each line and lines down each frame, and it handles both progressive scanning (one field per frame) and interlaced scanning (two fields per frame). Each line carries a programmed number of active samples followed by a programmed horizontal blanking interval. Each field carries a programmed number of active lines followed by a programmed vertical blanking interval. The outputs are active-video, horizontal-blank and vertical-blank flags, a field identifier, the current line number, a running flag and a mode-match flag.

Software writes mode values through a small write port into a staging copy. Writing 1 to the commit register requests that the staging copy be adopted. An idle generator adopts it on the next clock. A running generator adopts it only at the end of the current frame, so no frame is ever built from mixed settings. The generator stays idle until the first adoption. It is assumed that every length value is at least 1 and that the first-line number does not exceed the total lines per frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, and until the first commit is adopted, running_o, mode_match_o, active_o, hblank_o, vblank_o and field_o are 0 and line_o is 0.
- R2: Writes go to staging registers at these addresses: 0 = scan mode (bit 0: 1 interlaced, 0 progressive), 1 = active samples per line, 2 = horizontal blanking samples, 3 = field 0 active lines, 4 = field 1 active lines, 5 = blanking lines after field 0, 6 = blanking lines after field 1, 7 = number of the first active line, 8 = line number where field 1 begins, 9 = line number where field 0 begins. These writes leave the outputs unchanged until a commit (address 15, bit 0 = 1) is adopted. An idle generator adopts the commit on the clock after the write and shows the first active sample of field 0 in the following cycle.
- R3: Every line holds exactly `width` cycles with active_o possible and hblank_o low, followed by exactly `hblank` cycles with hblank_o high and active_o low.
- R4: In progressive mode a frame is `f0 lines` active lines followed by `blanking after field 0` lines with vblank_o high. field_o stays 0.
- R5: In interlaced mode a frame is field 0 active lines, then blanking-after-field-0 lines, then field 1 active lines, then blanking-after-field-1 lines. vblank_o is high exactly on the blanking lines.
- R6: The first active line of a frame carries line_o = first-line number. line_o increments by 1 on each following line and wraps from the frame total (the sum of all programmed line lengths) to 1.
- R7: In interlaced mode field_o becomes 1 on the line whose number equals the field-1 start value. It becomes 0 on the line whose number equals the field-0 start value. Otherwise it holds.
- R8: A commit made while running takes effect only at the first frame boundary. The frame in progress finishes with the old settings.
- R9: running_o and mode_match_o rise together when the first commit is adopted and stay 1 until reset.
- R10: Writing 0 to commit bit 0 before the boundary withdraws a pending request, and the current mode continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| active_o | output | 1 | Active picture sample |
| hblank_o | output | 1 | Horizontal blanking sample |
| vblank_o | output | 1 | Vertical blanking line |
| field_o | output | 1 | Field identifier |
| line_o | output | 16 | Current line number |
| running_o | output | 1 | Generator producing timing |
| mode_match_o | output | 1 | Programmed mode in use |

## Verification
A small progressive mode, whose first line is numbered 4, exercises line-number wrap and the single-field structure. A small interlaced mode exercises four unequal segments and field toggles on programmed lines that fall inside blanking. A second progressive mode is committed and then withdrawn while the interlaced mode is running, and later committed for real. The withdrawal shows whether cancelling is honoured. The real commit shows whether adoption waits for the frame boundary. A behavioural model is compared with every output on every clock, and whole-frame counts of active, blanking and field cycles confirm each geometry.

// File: rtl/rtg_pkg.sv
// Shared types for the raster timing generator.
// Assumes all programmed values fit in CW bits.
package rtg_pkg;
    parameter int CW = 16;

    typedef enum logic [1:0] {
        SEG_ACT0 = 2'd0,
        SEG_BLK0 = 2'd1,
        SEG_ACT1 = 2'd2,
        SEG_BLK1 = 2'd3
    } seg_e;

    typedef struct packed {
        logic          interlace;
        logic [CW-1:0] width;
        logic [CW-1:0] hblank;
        logic [CW-1:0] f0_lines;
        logic [CW-1:0] f1_lines;
        logic [CW-1:0] blank_a;
        logic [CW-1:0] blank_b;
        logic [CW-1:0] first_line;
        logic [CW-1:0] rise_line;
        logic [CW-1:0] fall_line;
    } mode_t;
endpackage

// File: rtl/rtg_mode_regs.sv
// Staging and live mode registers with a commit request flag.
// The live set changes only on apply. A commit write wins over a
// simultaneous apply-clear of the request.
module rtg_mode_regs
    import rtg_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          apply,
    output mode_t         stg,
    output mode_t         live,
    output logic          pend
);
    localparam logic [AW-1:0] A_MODE   = AW'(0);
    localparam logic [AW-1:0] A_WIDTH  = AW'(1);
    localparam logic [AW-1:0] A_HBLK   = AW'(2);
    localparam logic [AW-1:0] A_F0     = AW'(3);
    localparam logic [AW-1:0] A_F1     = AW'(4);
    localparam logic [AW-1:0] A_BLKA   = AW'(5);
    localparam logic [AW-1:0] A_BLKB   = AW'(6);
    localparam logic [AW-1:0] A_FIRST  = AW'(7);
    localparam logic [AW-1:0] A_RISE   = AW'(8);
    localparam logic [AW-1:0] A_FALL   = AW'(9);
    localparam logic [AW-1:0] A_COMMIT = AW'((1 << AW) - 1);

    logic commit_wr;
    assign commit_wr = wr_en && (wr_addr == A_COMMIT);

    // Purpose: capture register writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  stg.interlace  <= wr_data[0];
                A_WIDTH: stg.width      <= wr_data;
                A_HBLK:  stg.hblank     <= wr_data;
                A_F0:    stg.f0_lines   <= wr_data;
                A_F1:    stg.f1_lines   <= wr_data;
                A_BLKA:  stg.blank_a    <= wr_data;
                A_BLKB:  stg.blank_b    <= wr_data;
                A_FIRST: stg.first_line <= wr_data;
                A_RISE:  stg.rise_line  <= wr_data;
                A_FALL:  stg.fall_line  <= wr_data;
                default: ;
            endcase
        end
    end

    // Purpose: track the commit request, set or withdrawn by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (commit_wr) pend <= wr_data[0];
        else if (apply)     pend <= 1'b0;
    end

    // Purpose: adopt the staging copy as the live set on apply.
    always_ff @(posedge clk) begin
        if (!rst_n)     live <= '0;
        else if (apply) live <= stg;
    end

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(live)); // R8
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !commit_wr) |=> !pend); // R10
endmodule

// File: rtl/rtg_hcount.sv
// Sample counter along a line: width active samples then hblank samples.
// Assumes width and hblank are both at least 1 while running.
module rtg_hcount
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          restart,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] hblank,
    output logic          line_end,
    output logic          in_act
);
    localparam int SW = CW + 1;

    logic [SW-1:0] sx;
    logic [SW-1:0] line_len;

    assign line_len = SW'(width) + SW'(hblank);
    assign line_end = running && (sx == line_len - 1'b1);
    assign in_act   = sx < SW'(width);

    // Purpose: advance the sample position and wrap at the end of a line.
    always_ff @(posedge clk) begin
        if (!rst_n)        sx <= '0;
        else if (restart)  sx <= '0;
        else if (line_end) sx <= '0;
        else if (running)  sx <= sx + 1'b1;
    end

    AST_SX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (sx < line_len)); // R3
endmodule

// File: rtl/rtg_vseq.sv
// Line sequencer: segment order, line numbering and field flag.
// Assumes every segment length is at least 1 and first_line <= total.
module rtg_vseq
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          restart,
    input  logic          line_end,
    input  mode_t         live,
    input  mode_t         nxt,
    output seg_e          seg,
    output logic [CW-1:0] ln,
    output logic          field,
    output logic          frame_end
);
    localparam int TW = CW + 2;

    logic [CW-1:0] segcnt;
    logic [CW-1:0] seg_len;
    logic          seg_last;
    seg_e          seg_nxt;
    logic [TW-1:0] total;
    logic [CW-1:0] ln_nxt;

    function automatic logic fld_upd(input logic cur, input logic il,
                                     input logic [CW-1:0] n,
                                     input logic [CW-1:0] r,
                                     input logic [CW-1:0] f);
        if (!il)         return 1'b0;
        else if (n == r) return 1'b1;
        else if (n == f) return 1'b0;
        else             return cur;
    endfunction

    // Purpose: pick the length of the current segment and its successor.
    always_comb begin
        case (seg)
            SEG_ACT0: begin seg_len = live.f0_lines; seg_nxt = SEG_BLK0; end
            SEG_BLK0: begin
                seg_len = live.blank_a;
                seg_nxt = live.interlace ? SEG_ACT1 : SEG_ACT0;
            end
            SEG_ACT1: begin seg_len = live.f1_lines; seg_nxt = SEG_BLK1; end
            default:  begin seg_len = live.blank_b;  seg_nxt = SEG_ACT0; end
        endcase
    end

    assign seg_last  = (segcnt == seg_len - 1'b1);
    assign frame_end = line_end && seg_last &&
                       ((seg == SEG_BLK1) || ((seg == SEG_BLK0) && !live.interlace));
    assign total     = live.interlace ?
                       (TW'(live.f0_lines) + TW'(live.blank_a) + TW'(live.f1_lines) + TW'(live.blank_b)) :
                       (TW'(live.f0_lines) + TW'(live.blank_a));
    assign ln_nxt    = (TW'(ln) == total) ? CW'(1) : ln + 1'b1;

    // Purpose: step through segments and count lines within each.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seg    <= SEG_ACT0;
            segcnt <= '0;
        end else if (line_end) begin
            if (seg_last) begin
                seg    <= seg_nxt;
                segcnt <= '0;
            end else begin
                segcnt <= segcnt + 1'b1;
            end
        end
    end

    // Purpose: number lines and flip the field flag on programmed lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln    <= '0;
            field <= 1'b0;
        end else if (restart) begin
            ln    <= nxt.first_line;
            field <= fld_upd(1'b0, nxt.interlace, nxt.first_line, nxt.rise_line, nxt.fall_line);
        end else if (line_end) begin
            ln    <= ln_nxt;
            field <= fld_upd(field, live.interlace, ln_nxt, live.rise_line, live.fall_line);
        end
    end

    AST_LN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (ln >= CW'(1) && TW'(ln) <= total)); // R6
    AST_LN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !line_end && !restart) |=> $stable(ln)); // R6
    AST_PROG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !live.interlace |-> !field); // R7
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator: mode registers, sample counter
// and line sequencer, plus the running and mode-match flags.
// Assumes software programs consistent, non-zero lengths before commit.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          active_o,
    output logic          hblank_o,
    output logic          vblank_o,
    output logic          field_o,
    output logic [CW-1:0] line_o,
    output logic          running_o,
    output logic          mode_match_o
);
    mode_t         stg, live;
    logic          pend, apply, running, matched;
    logic          line_end, in_act, frame_end, field;
    seg_e          seg;
    logic [CW-1:0] ln;

    assign apply = pend && (!running || frame_end);

    rtg_mode_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .apply(apply), .stg(stg), .live(live), .pend(pend)
    );

    rtg_hcount hcnt_i (
        .clk(clk), .rst_n(rst_n), .running(running), .restart(apply),
        .width(live.width), .hblank(live.hblank),
        .line_end(line_end), .in_act(in_act)
    );

    rtg_vseq vseq_i (
        .clk(clk), .rst_n(rst_n), .running(running), .restart(apply),
        .line_end(line_end), .live(live), .nxt(stg), .seg(seg), .ln(ln),
        .field(field), .frame_end(frame_end)
    );

    // Purpose: set the running and match flags on the first adoption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            matched <= 1'b0;
        end else if (apply) begin
            running <= 1'b1;
            matched <= 1'b1;
        end
    end

    assign vblank_o     = running && ((seg == SEG_BLK0) || (seg == SEG_BLK1));
    assign active_o     = running && in_act && !vblank_o;
    assign hblank_o     = running && !in_act;
    assign field_o      = field;
    assign line_o       = ln;
    assign running_o    = running;
    assign mode_match_o = matched;

    AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_match_o |=> mode_match_o); // R9
    AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> mode_match_o); // R9
endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        active_o, hblank_o, vblank_o, field_o, running_o, mode_match_o;
    logic [15:0] line_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    raster_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .active_o(active_o), .hblank_o(hblank_o),
        .vblank_o(vblank_o), .field_o(field_o), .line_o(line_o),
        .running_o(running_o), .mode_match_o(mode_match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: staging[0..9], live set, position in frame.
    int st[10];
    int lv[10];
    int m_pend, m_run, m_match, m_sx, m_k, m_ln, m_field;

    function automatic int tot_of(input int c[10]);
        return c[0] != 0 ? c[3] + c[5] + c[4] + c[6] : c[3] + c[5];
    endfunction

    function automatic int fupd(input int cur, input int il, input int n, input int r, input int f);
        if (il == 0) return 0;
        if (n == r) return 1;
        if (n == f) return 0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_run = 0; m_match = 0; m_sx = 0; m_k = 0; m_ln = 0; m_field = 0;
            foreach (st[i]) begin st[i] = 0; lv[i] = 0; end
        end else begin
            int L, T, fe, ap;
            L  = lv[1] + lv[2];
            T  = tot_of(lv);
            fe = (m_run != 0) && (m_sx == L - 1) && (m_k == T - 1);
            ap = (m_pend != 0) && ((m_run == 0) || (fe != 0));
            if (ap) begin
                lv = st;
                m_run = 1; m_match = 1; m_sx = 0; m_k = 0; m_ln = st[7];
                m_field = fupd(0, st[0], st[7], st[8], st[9]);
            end else if (m_run != 0) begin
                if (m_sx == L - 1) begin
                    m_sx = 0;
                    m_k  = (m_k + 1) % T;
                    m_ln = (m_ln == T) ? 1 : m_ln + 1;
                    m_field = fupd(m_field, lv[0], m_ln, lv[8], lv[9]);
                end else begin
                    m_sx++;
                end
            end
            if (wr_en && wr_addr == 4'd15) m_pend = wr_data[0];
            else if (ap) m_pend = 0;
            if (wr_en && wr_addr <= 4'd9)
                st[wr_addr] = (wr_addr == 4'd0) ? int'(wr_data[0]) : int'(wr_data);
        end
    end

    // Compare every output against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int e_vb, e_act, e_hb;
            e_vb  = (m_run != 0) && (((m_k >= lv[3]) && (m_k < lv[3] + lv[5])) ||
                    ((lv[0] != 0) && (m_k >= lv[3] + lv[5] + lv[4])));
            e_hb  = (m_run != 0) && (m_sx >= lv[1]);
            e_act = (m_run != 0) && !e_vb && (m_sx < lv[1]);
            chk("R3 hblank", hblank_o, e_hb);
            chk("R5 active", active_o, e_act);
            chk("R4 vblank", vblank_o, e_vb);
            chk("R6 line", line_o, m_run != 0 ? m_ln : 0);
            chk("R7 field", field_o, m_field);
            chk("R9 running", running_o, m_run);
            chk("R9 match", mode_match_o, m_match);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input int il, input int w, input int h, input int f0, input int f1,
                        input int ba, input int bb, input int fl, input int r, input int f);
        wr(0, il); wr(1, w); wr(2, h); wr(3, f0); wr(4, f1);
        wr(5, ba); wr(6, bb); wr(7, fl); wr(8, r); wr(9, f);
    endtask

    // Wait for the first sample of a frame whose first line number is fl.
    task automatic wait_frame(input int fl);
        int prev;
        prev = line_o;
        @(negedge clk);
        while (!(line_o == 16'(fl) && prev != fl && running_o)) begin
            prev = line_o;
            @(negedge clk);
        end
    endtask

    int c_act, c_vb, c_fld, rise_ln, fall_ln;
    task automatic measure(input int n);
        int pf;
        c_act = 0; c_vb = 0; c_fld = 0; rise_ln = -1; fall_ln = -1;
        pf = field_o;
        repeat (n) begin
            c_act += active_o; c_vb += vblank_o; c_fld += field_o;
            if (field_o && !pf) rise_ln = line_o;
            if (!field_o && pf) fall_ln = line_o;
            pf = field_o;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running", running_o, 0);
        chk("R1 match", mode_match_o, 0);
        chk("R1 line", line_o, 0);
        chk("R1 flags", {active_o, hblank_o, vblank_o, field_o}, 0);
        cmp_on = 1;

        // Progressive P: W4 H3 f0=5 blank=3 first=4 (total 8, L=7)
        prog(0, 4, 3, 5, 2, 3, 2, 4, 0, 0);
        repeat (8) @(negedge clk);
        chk("R2 idle before commit", running_o, 0);
        wr(15, 1);
        @(negedge clk);
        chk("R2 started", running_o, 1);
        chk("R2 first line", line_o, 4);
        chk("R9 match", mode_match_o, 1);
        measure(112);
        chk("R3 active cycles P", c_act, 40);
        chk("R4 vblank cycles P", c_vb, 42);
        chk("R4 field P", c_fld, 0);

        // Interlaced I: W5 H2 f0=4 ba=2 f1=3 bb=3 first=2 rise=6 fall=11
        prog(1, 5, 2, 4, 3, 2, 3, 2, 6, 11);
        wr(15, 1);
        chk("R8 old mode kept", field_o, 0);
        wait_frame(2);
        measure(168);
        chk("R5 active cycles I", c_act, 70);
        chk("R5 vblank cycles I", c_vb, 70);
        chk("R7 field1 cycles", c_fld, 70);
        chk("R7 rise line", rise_ln, 6);
        chk("R7 fall line", fall_ln, 11);

        // R10: stage B, request then withdraw; I must continue.
        prog(0, 3, 2, 2, 1, 2, 1, 1, 0, 0);
        wr(15, 1);
        wr(15, 0);
        wait_frame(2);
        measure(168);
        chk("R10 withdrawn, field1 cycles", c_fld, 70);
        chk("R10 withdrawn, active", c_act, 70);

        // R8: commit B for real; adopted at a frame boundary.
        wr(15, 1);
        wait_frame(1);
        measure(40);
        chk("R8 B active", c_act, 12);
        chk("R8 B vblank", c_vb, 20);
        chk("R8 B field", c_fld, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule